// File: doc/BRIEF.md
# Flagged Arithmetic-Logic Unit

This block is the 32-bit arithmetic-logic stage of a word-oriented processor core running in its native mode. Each cycle it may accept an operation code, two operands, the index of the destination register and the current carry flag. One clock edge later it presents the result, a write strobe for the register file, and new values for the overflow, carry, negative and zero flags. Each flag has its own update strobe, so the status register only changes the flags that the operation defines.

The unit has no separate compare or bit-test codes. A subtract aimed at register 0 behaves as a compare, and an and aimed at register 0 behaves as a bit test. Register 0 always reads as zero, so no operation ever writes to it, and for these two operations the target index also changes which flags are updated. The register file, memory operands and decimal arithmetic are handled elsewhere.

Top module: `flagged_alu`

## Requirements
- R1: While reset is asserted (synchronous, active low) every output is driven to zero.
- R2: Outputs change one clock edge after a cycle with `in_valid` high. After a cycle with `in_valid` low, the write strobe and all four flag strobes are low and the result holds its previous value.
- R3: Code 0 (add) gives A+B with carry-in ignored. Carry is the unsigned carry-out, overflow is signed overflow, and all four flag strobes are high.
- R4: Code 1 (subtract) with a non-zero target gives A-B. Carry is set when A >= B unsigned (no borrow), overflow is signed overflow, and all four flag strobes are high.
- R5: Code 1 with target 0 is a compare. There is no write, and the carry, negative and zero strobes are high while the overflow strobe is low.
- R6: Codes 2 (and), 3 (or) and 4 (exclusive-or) raise only the negative and zero strobes, except as R7 states.
- R7: Code 2 with target 0 is a bit test. There is no write, and the negative, zero and overflow strobes are high. The overflow value is bit 30 of A AND B, and the carry strobe is low.
- R8: Code 5 shifts A left by one and code 6 shifts A right by one, filling with zero. Carry takes the bit shifted out. The carry, negative and zero strobes are high and B is ignored.
- R9: Code 7 rotates A left with the old carry entering bit 0, and code 8 rotates A right with the old carry entering bit 31. Carry takes the bit shifted out. The carry, negative and zero strobes are high.
- R10: The negative value is result bit 31, and the zero value is high exactly when all 32 result bits are zero.
- R11: A target index of 0 never raises the write strobe. For codes 0, 3, 4 and 5 to 8 the flag strobes are unchanged by the target index.
- R12: Codes 9 to 15 raise no strobe and give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see requirements) |
| tgt | input | 4 | Destination register index |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| carry_in | input | 1 | Current carry flag |
| res_q | output | 32 | Registered result |
| wen_q | output | 1 | Destination write strobe |
| v_q | output | 1 | New overflow value |
| c_q | output | 1 | New carry value |
| n_q | output | 1 | New negative value |
| z_q | output | 1 | New zero value |
| v_en_q | output | 1 | Overflow update strobe |
| c_en_q | output | 1 | Carry update strobe |
| n_en_q | output | 1 | Negative update strobe |
| z_en_q | output | 1 | Zero update strobe |

## Verification
Random operand pairs across all sixteen codes, with random targets and carry-in, cover the ordinary add, subtract, logic and shift paths. A target of 0 occurs often enough that the compare and bit-test strobe sets are told apart from plain subtract and and. Directed operands check the flags where they are easiest to get wrong: signed overflow at 0x7FFFFFFF+1, carry-out with a zero result at 0xFFFFFFFF+1, equal and borrowing subtracts, and bit 30 set with bit 31 clear for the bit test. Rotates are run with both carry-in values, so a rotate is told apart from a plain shift.

// File: rtl/flagged_alu_pkg.sv
// Shared operation codes and the strobe bundle for the flagged ALU.
package flagged_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_ASL = 4'd5,
        OP_LSR = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8
    } alu_op_e;

    // Per-operation strobes plus the select for the bit-test overflow source.
    typedef struct packed {
        logic wen;
        logic v_en;
        logic c_en;
        logic n_en;
        logic z_en;
        logic v_bit;
    } flag_ctl_t;

endpackage

// File: rtl/falu_adder.sv
// Adder/subtractor. Subtract is A + ~B + 1, so carry-out means "no borrow".
// Assumes W >= 2. Fully combinational.
module falu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    // Form the second operand and the full-width sum with carry.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/falu_logic.sv
// Bitwise unit: sel 0 = and, 1 = or, 2 = exclusive-or, 3 = zero.
// One slice per bit. Fully combinational.
module falu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Pick the function for this bit position.
        always_comb begin
            unique case (sel)
                2'd0:    y[i] = a[i] & b[i];
                2'd1:    y[i] = a[i] | b[i];
                2'd2:    y[i] = a[i] ^ b[i];
                default: y[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/falu_shifter.sv
// One-bit shifter. A rotate feeds the old carry into the vacated end,
// a shift feeds zero. cout is the bit that leaves the word. Combinational.
module falu_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic         left,
    input  logic         rotate,
    output logic [W-1:0] y,
    output logic         cout
);
    logic fill;

    // Choose the fill bit and move the word one place.
    always_comb begin
        fill = rotate & cin;
        if (left) begin
            y    = {a[W-2:0], fill};
            cout = a[W-1];
        end else begin
            y    = {fill, a[W-1:1]};
            cout = a[0];
        end
    end
endmodule

// File: rtl/falu_flag_policy.sv
// Decides which strobes an operation raises. A target of register 0 blocks
// the write and turns subtract into compare and and into bit test.
module falu_flag_policy (
    input  logic                         valid,
    input  logic [3:0]                   op,
    input  logic                         tgt_zero,
    output flagged_alu_pkg::flag_ctl_t   ctl
);
    import flagged_alu_pkg::*;

    // Strobe table per operation, all gated by valid.
    always_comb begin
        ctl = '0;
        if (valid) begin
            case (op)
                OP_ADD: begin
                    ctl.wen = !tgt_zero;
                    ctl.v_en = 1'b1; ctl.c_en = 1'b1;
                    ctl.n_en = 1'b1; ctl.z_en = 1'b1;
                end
                OP_SUB: begin
                    ctl.wen  = !tgt_zero;
                    ctl.v_en = !tgt_zero;
                    ctl.c_en = 1'b1; ctl.n_en = 1'b1; ctl.z_en = 1'b1;
                end
                OP_AND: begin
                    ctl.wen   = !tgt_zero;
                    ctl.v_en  = tgt_zero;
                    ctl.v_bit = tgt_zero;
                    ctl.n_en  = 1'b1; ctl.z_en = 1'b1;
                end
                OP_OR, OP_XOR: begin
                    ctl.wen  = !tgt_zero;
                    ctl.n_en = 1'b1; ctl.z_en = 1'b1;
                end
                OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                    ctl.wen  = !tgt_zero;
                    ctl.c_en = 1'b1; ctl.n_en = 1'b1; ctl.z_en = 1'b1;
                end
                default: ctl = '0;
            endcase
        end
    end
endmodule

// File: rtl/flagged_alu.sv
// Top of the flagged ALU. Combines the arithmetic, logic and shift units,
// applies the flag policy and registers everything once.
// Assumes W >= 2; the bit-test overflow source is bit W-2.
module flagged_alu #(
    parameter int W    = 32,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op,
    input  logic [IDXW-1:0] tgt,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic            carry_in,
    output logic [W-1:0]    res_q,
    output logic            wen_q,
    output logic            v_q,
    output logic            c_q,
    output logic            n_q,
    output logic            z_q,
    output logic            v_en_q,
    output logic            c_en_q,
    output logic            n_en_q,
    output logic            z_en_q
);
    import flagged_alu_pkg::*;

    logic [W-1:0] add_y, log_y, sh_y, res_d;
    logic         add_c, add_v, sh_c;
    logic [1:0]   log_sel;
    logic         is_shift, sh_left, sh_rot;
    logic         v_d, c_d;
    flag_ctl_t    ctl;

    // Decode unit selects from the operation code.
    always_comb begin
        is_shift = (op == OP_ASL) || (op == OP_LSR) || (op == OP_ROL) || (op == OP_ROR);
        sh_left  = (op == OP_ASL) || (op == OP_ROL);
        sh_rot   = (op == OP_ROL) || (op == OP_ROR);
        case (op)
            OP_AND:  log_sel = 2'd0;
            OP_OR:   log_sel = 2'd1;
            OP_XOR:  log_sel = 2'd2;
            default: log_sel = 2'd3;
        endcase
    end

    falu_adder #(.W(W)) u_add (
        .a(opa), .b(opb), .sub(op == OP_SUB),
        .sum(add_y), .cout(add_c), .ovf(add_v)
    );

    falu_logic #(.W(W)) u_log (
        .a(opa), .b(opb), .sel(log_sel), .y(log_y)
    );

    falu_shifter #(.W(W)) u_sh (
        .a(opa), .cin(carry_in), .left(sh_left), .rotate(sh_rot),
        .y(sh_y), .cout(sh_c)
    );

    falu_flag_policy u_pol (
        .valid(in_valid), .op(op), .tgt_zero(tgt == '0), .ctl(ctl)
    );

    // Pick the result and the raw overflow and carry values.
    always_comb begin
        if (op == OP_ADD || op == OP_SUB)           res_d = add_y;
        else if (is_shift)                          res_d = sh_y;
        else if (log_sel != 2'd3)                   res_d = log_y;
        else                                        res_d = '0;
        v_d = ctl.v_bit ? res_d[W-2] : add_v;
        c_d = is_shift ? sh_c : add_c;
    end

    // Output register stage; data holds while idle, strobes clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            wen_q  <= 1'b0;
            v_q    <= 1'b0; c_q    <= 1'b0; n_q    <= 1'b0; z_q    <= 1'b0;
            v_en_q <= 1'b0; c_en_q <= 1'b0; n_en_q <= 1'b0; z_en_q <= 1'b0;
        end else begin
            wen_q  <= ctl.wen;
            v_en_q <= ctl.v_en;
            c_en_q <= ctl.c_en;
            n_en_q <= ctl.n_en;
            z_en_q <= ctl.z_en;
            if (in_valid) begin
                res_q <= res_d;
                v_q   <= v_d;
                c_q   <= c_d;
                n_q   <= res_d[W-1];
                z_q   <= (res_d == '0);
            end
        end
    end
endmodule

// File: rtl/flagged_alu_chk.sv
// Property checker for the flagged ALU, attached through bind.
module flagged_alu_chk #(
    parameter int W    = 32,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [3:0]      op,
    input logic [IDXW-1:0] tgt,
    input logic [W-1:0]    opa,
    input logic [W-1:0]    opb,
    input logic [W-1:0]    res_q,
    input logic            wen_q,
    input logic            v_q,
    input logic            n_q,
    input logic            z_q,
    input logic            v_en_q,
    input logic            c_en_q,
    input logic            n_en_q,
    input logic            z_en_q
);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wen_q && !v_en_q && !c_en_q && !n_en_q && !z_en_q));

    assert_cmp_keeps_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd1 && tgt == '0) |=> (!wen_q && !v_en_q && c_en_q && z_en_q));

    assert_logic_nz_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd3 || op == 4'd4)) |=> (!v_en_q && !c_en_q && n_en_q && z_en_q));

    assert_bit_v_from_b30_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd2 && tgt == '0) |=>
        (v_en_q && !c_en_q && !wen_q && v_q == $past(opa[W-2] & opb[W-2])));

    assert_nz_match_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (n_en_q && z_en_q) |-> (n_q == res_q[W-1] && z_q == (res_q == '0)));

    assert_no_write_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tgt == '0) |=> !wen_q);

    assert_unused_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd8) |=> (!wen_q && !v_en_q && !c_en_q && !n_en_q && !z_en_q));
endmodule

bind flagged_alu flagged_alu_chk #(.W(W), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .tgt(tgt),
    .opa(opa), .opb(opb), .res_q(res_q), .wen_q(wen_q), .v_q(v_q),
    .n_q(n_q), .z_q(z_q), .v_en_q(v_en_q), .c_en_q(c_en_q),
    .n_en_q(n_en_q), .z_en_q(z_en_q)
);

// File: tb/sim_flagged_alu.sv
module sim_flagged_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [3:0]  tgt = '0;
    logic [31:0] opa = '0, opb = '0;
    logic        carry_in = 1'b0;
    logic [31:0] res_q;
    logic wen_q, v_q, c_q, n_q, z_q, v_en_q, c_en_q, n_en_q, z_en_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -SMAX - 1;

    always #10 clk = ~clk;

    flagged_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .tgt(tgt),
        .opa(opa), .opb(opb), .carry_in(carry_in), .res_q(res_q),
        .wen_q(wen_q), .v_q(v_q), .c_q(c_q), .n_q(n_q), .z_q(z_q),
        .v_en_q(v_en_q), .c_en_q(c_en_q), .n_en_q(n_en_q), .z_en_q(z_en_q)
    );

    // Reference model: {result, wen, v_en, c_en, n_en, z_en, v, c, n, z},
    // each flag value masked by its own strobe.
    function automatic logic [40:0] model(input logic [3:0] o, input logic [3:0] t,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic ci);
        logic [31:0] r;
        logic v, c, ve, ce, ne, ze, we, tz;
        longint s;
        tz = (t == 0);
        r = '0; v = 0; c = 0; ve = 0; ce = 0; ne = 0; ze = 0; we = 0;
        case (o)
            4'd0: begin
                r = a + b; c = ({1'b0, a} + {1'b0, b}) > 33'h0FFFFFFFF;
                s = longint'($signed(a)) + longint'($signed(b));
                v = (s > SMAX) || (s < SMIN);
                we = !tz; ve = 1; ce = 1; ne = 1; ze = 1;
            end
            4'd1: begin
                r = a - b; c = (a >= b);
                s = longint'($signed(a)) - longint'($signed(b));
                v = (s > SMAX) || (s < SMIN);
                we = !tz; ve = !tz; ce = 1; ne = 1; ze = 1;
            end
            4'd2: begin r = a & b; we = !tz; ve = tz; v = r[30]; ne = 1; ze = 1; end
            4'd3: begin r = a | b; we = !tz; ne = 1; ze = 1; end
            4'd4: begin r = a ^ b; we = !tz; ne = 1; ze = 1; end
            4'd5: begin r = a << 1; c = a[31]; we = !tz; ce = 1; ne = 1; ze = 1; end
            4'd6: begin r = a >> 1; c = a[0];  we = !tz; ce = 1; ne = 1; ze = 1; end
            4'd7: begin r = {a[30:0], ci}; c = a[31]; we = !tz; ce = 1; ne = 1; ze = 1; end
            4'd8: begin r = {ci, a[31:1]}; c = a[0];  we = !tz; ce = 1; ne = 1; ze = 1; end
            default: ;
        endcase
        return {r, we, ve, ce, ne, ze, v & ve, c & ce, r[31] & ne, (r == 0) & ze};
    endfunction

    function automatic string req_of(input logic [3:0] o, input logic [3:0] t);
        case (o)
            4'd0: return "R3";
            4'd1: return (t == 0) ? "R5" : "R4";
            4'd2: return (t == 0) ? "R7" : "R6";
            4'd3, 4'd4: return "R6";
            4'd5, 4'd6: return "R8";
            4'd7, 4'd8: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation, wait for its registered result and compare.
    task automatic run(input logic [3:0] o, input logic [3:0] t, input logic [31:0] a,
                       input logic [31:0] b, input logic ci, input string req);
        logic [40:0] e, got;
        op = o; tgt = t; opa = a; opb = b; carry_in = ci; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        e = model(o, t, a, b, ci);
        got = {res_q, wen_q, v_en_q, c_en_q, n_en_q, z_en_q,
               v_q & e[7], c_q & e[6], n_q & e[5], z_q & e[4]};
        check((req == "") ? req_of(o, t) : req, got, e);
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {res_q, wen_q, v_q, c_q, n_q, z_q, v_en_q, c_en_q, n_en_q, z_en_q}, '0);
        rst_n = 1'b1;

        run(4'd0, 4'd1, 32'h7FFFFFFF, 32'h1, 1'b1, "R3");
        run(4'd0, 4'd2, 32'hFFFFFFFF, 32'h1, 1'b0, "R3");
        run(4'd1, 4'd3, 32'h1234, 32'h1234, 1'b0, "R4");
        run(4'd1, 4'd3, 32'h0, 32'h1, 1'b0, "R4");
        run(4'd1, 4'd3, 32'h80000000, 32'h1, 1'b0, "R4");
        run(4'd1, 4'd0, 32'h80000000, 32'h1, 1'b0, "R5");
        run(4'd2, 4'd0, 32'h40000000, 32'h7FFFFFFF, 1'b0, "R7");
        run(4'd2, 4'd0, 32'h80000000, 32'hBFFFFFFF, 1'b1, "R7");
        run(4'd4, 4'd5, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b0, "R10");
        run(4'd5, 4'd6, 32'h80000000, 32'hFFFFFFFF, 1'b0, "R8");
        run(4'd6, 4'd6, 32'h00000001, 32'h0, 1'b1, "R8");
        run(4'd7, 4'd7, 32'h80000000, 32'h0, 1'b1, "R9");
        run(4'd8, 4'd7, 32'h00000001, 32'h0, 1'b1, "R9");
        run(4'd8, 4'd7, 32'h00000002, 32'h0, 1'b0, "R9");
        run(4'd3, 4'd0, 32'h80000000, 32'h0, 1'b0, "R11");
        run(4'd0, 4'd0, 32'h1, 32'h2, 1'b0, "R11");
        run(4'd12, 4'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R12");

        // R2: an idle cycle clears every strobe and keeps the result.
        run(4'd3, 4'd9, 32'h00F0, 32'h0F00, 1'b0, "R6");
        held = res_q;
        in_valid = 1'b0;
        op = 4'd0; tgt = 4'd1; opa = 32'h5; opb = 32'h5;
        @(posedge clk);
        @(negedge clk);
        check("R2", {res_q, wen_q, v_en_q, c_en_q, n_en_q, z_en_q}, {held, 5'b0});

        for (int i = 0; i < 400; i++) begin
            logic [3:0] ro, rt;
            ro = 4'($urandom_range(0, 15));
            rt = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom);
            run(ro, rt, $urandom, $urandom, 1'($urandom), "");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule